// File: doc/BRIEF.md
# Double-Banked Longest-Prefix Next-Hop Lookup

This block takes a 32-bit IPv4 destination address and returns the number of the outbound port that should carry the packet. It uses a small table of network routes. Each route has a valid flag, a prefix value, a prefix length and an output port. All entries are compared with the address in parallel. The matching entry with the longest prefix wins. If nothing matches, the block reports a miss and returns a default port that software sets. The address is treated as an unsigned 32-bit number, and a length of n compares only its n most significant bits.

The route table exists twice. One bank serves lookups. The control processor rewrites the other bank through a plain write port. A one-cycle swap strobe then makes the rewritten bank the active one. The swap takes effect on a lookup boundary, so no request is dropped and no request sees a mix of the two tables.

Lookups use a valid/ready request channel and a valid/ready response channel. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. The search result is registered at that edge. `req_ready` is high whenever the response register is empty or is being drained in the same cycle. When the consumer holds `rsp_ready` low, the response stays frozen and no new request is accepted. This gives one lookup per cycle when the consumer is always ready.

Top module: `nh_lookup_top`

## Requirements
- R1: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `rsp_valid` is high in the cycle that follows. `req_ready` equals `!rsp_valid || rsp_ready`. `rsp_valid` falls after a cycle in which `rsp_ready` was high and no request was accepted.
- R2: While `rsp_valid` is high and `rsp_ready` is low, `rsp_port` and `rsp_hit` hold their values and `req_ready` is low, so a waiting request is not taken.
- R3: An entry matches when its valid flag is set and the top L address bits equal the top L bits of its prefix. L is the stored length, with any value above 32 treated as 32. A length of 0 matches every address. On a hit, `rsp_hit` is 1 and `rsp_port` is the winning entry's port.
- R4: When several entries match, the one with the greatest effective length wins. Among entries of equal length, the lowest index wins.
- R5: When no entry matches, `rsp_hit` is 0 and `rsp_port` equals `dflt_port` as sampled on the accepting edge.
- R6: A write (`wr_en` high) whose `wr_bank` differs from `active_bank` stores `{wr_vld, wr_prefix, wr_len, wr_port}` into entry `wr_idx` of that bank. A write whose `wr_bank` equals `active_bank` in that cycle changes nothing. Lookups search only the active bank.
- R7: Writing an entry with `wr_vld` at 0 removes it: that entry matches no address afterwards.
- R8: A `swap` pulse inverts `active_bank` on the next clock edge. A request accepted on that same edge is answered from the old bank. Every request accepted later is answered from the new bank.
- R9: After reset, `active_bank` is 0, `rsp_valid` is 0 and every entry of both banks is invalid, so every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A lookup request is present |
| req_ready | output | 1 | The block can take a request this cycle |
| req_addr | input | 32 | Destination address to look up |
| rsp_valid | output | 1 | A lookup result is present |
| rsp_ready | input | 1 | The consumer takes the result this cycle |
| rsp_hit | output | 1 | 1 when some entry matched |
| rsp_port | output | 4 | Selected output port, or the default port on a miss |
| dflt_port | input | 4 | Port returned on a miss |
| wr_en | input | 1 | Table write strobe |
| wr_bank | input | 1 | Bank the write is aimed at |
| wr_idx | input | 4 | Entry index within the bank |
| wr_vld | input | 1 | Valid flag to store |
| wr_prefix | input | 32 | Prefix value to store |
| wr_len | input | 6 | Prefix length to store (values above 32 act as 32) |
| wr_port | input | 4 | Output port to store |
| swap | input | 1 | One-cycle pulse that exchanges the active and shadow banks |
| active_bank | output | 1 | Index of the bank that currently serves lookups |

## Verification
The lookup function is swept over three kinds of address for every valid entry. The first is the prefix itself. The second is the prefix with all host bits set; this separates a correct length mask from one that is off by one bit. The third is the prefix with its last network bit flipped; this must fall back to a shorter route or miss. On top of this come 32 walking-one addresses and a few hundred pseudo-random addresses. All of these are compared with a longest-match model in the bench. The tables include nested prefixes to exercise length priority, a duplicated route to exercise the lowest-index tie rule, a length above 32, and a zero-length default route, so that hits, ties and misses are each told apart. Separate directed runs cover the other cases: writes aimed at the active bank, removal of an entry, a swap on the same edge as an accepted request, a change of the default port, and a stalled response.

// File: rtl/nh_pkg.sv
package nh_pkg;

  // Address, port and table sizing shared by every module of the block.
  parameter int unsigned NH_ADDR_W  = 32;
  parameter int unsigned NH_PORT_W  = 4;
  parameter int unsigned NH_ENTRIES = 16;

  // Width needed to hold any length from 0 to NH_ADDR_W, plus headroom.
  localparam int unsigned NH_LEN_W = $clog2(NH_ADDR_W + 1) + 0;

  // One route: valid flag, network prefix, prefix length, output port.
  typedef struct packed {
    logic                 vld;
    logic [NH_ADDR_W-1:0] pfx;
    logic [NH_LEN_W-1:0]  len;
    logic [NH_PORT_W-1:0] port;
  } nh_entry_t;

endpackage

// File: rtl/nh_bank.sv
module nh_bank
  import nh_pkg::*;
#(
  parameter int unsigned ENTRIES = NH_ENTRIES,
  parameter int unsigned IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [IDX_W-1:0]          idx,
  input  nh_entry_t                 wdata,
  output nh_entry_t [ENTRIES-1:0]   tbl
);

  nh_entry_t [ENTRIES-1:0] tbl_q;

  // Reset empties the bank. Each entry is written as a whole.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbl_q <= '0;
    end else if (we && (32'(idx) < ENTRIES)) begin
      tbl_q[idx] <= wdata;
    end
  end

  assign tbl = tbl_q;

endmodule

// File: rtl/nh_prefix_cmp.sv
module nh_prefix_cmp
  import nh_pkg::*;
(
  input  logic [NH_ADDR_W-1:0] key,
  input  nh_entry_t            ent,
  output logic                 hit,
  output logic [NH_LEN_W-1:0]  eff_len
);

  localparam logic [NH_LEN_W-1:0]  MAX_LEN = NH_LEN_W'(NH_ADDR_W);
  localparam logic [NH_ADDR_W-1:0] ONES    = '1;

  logic [NH_ADDR_W-1:0] net_mask;

  // Any stored length beyond the address width behaves as a host route.
  assign eff_len = (ent.len > MAX_LEN) ? MAX_LEN : ent.len;

  // Top eff_len bits set: a zero length keeps nothing, a full length keeps all.
  assign net_mask = ~(ONES >> eff_len);

  assign hit = ent.vld && (((key ^ ent.pfx) & net_mask) == '0);

endmodule

// File: rtl/nh_match.sv
module nh_match
  import nh_pkg::*;
#(
  parameter int unsigned ENTRIES = NH_ENTRIES
) (
  input  logic [NH_ADDR_W-1:0]     key,
  input  nh_entry_t [ENTRIES-1:0]  tbl,
  output logic                     hit,
  output logic [NH_PORT_W-1:0]     port
);

  logic [ENTRIES-1:0]  ent_hit;
  logic [NH_LEN_W-1:0] ent_len [ENTRIES];

  // One comparator per entry, all working at once.
  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    nh_prefix_cmp u_cmp (
      .key     (key),
      .ent     (tbl[e]),
      .hit     (ent_hit[e]),
      .eff_len (ent_len[e])
    );
  end

  // Scan in ascending index order. Only a strictly longer length replaces
  // the current winner, so the lowest index keeps a tie.
  logic                 any_q;
  logic [NH_LEN_W-1:0]  best_len;
  logic [NH_PORT_W-1:0] best_port;

  always_comb begin
    any_q     = 1'b0;
    best_len  = '0;
    best_port = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (ent_hit[i] && (!any_q || (ent_len[i] > best_len))) begin
        any_q     = 1'b1;
        best_len  = ent_len[i];
        best_port = tbl[i].port;
      end
    end
  end

  assign hit  = any_q;
  assign port = best_port;

endmodule

// File: rtl/nh_lookup_top.sv
module nh_lookup_top
  import nh_pkg::*;
#(
  parameter int unsigned ENTRIES = NH_ENTRIES,
  parameter int unsigned IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [NH_ADDR_W-1:0]  req_addr,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic                  rsp_hit,
  output logic [NH_PORT_W-1:0]  rsp_port,
  input  logic [NH_PORT_W-1:0]  dflt_port,
  input  logic                  wr_en,
  input  logic                  wr_bank,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic                  wr_vld,
  input  logic [NH_ADDR_W-1:0]  wr_prefix,
  input  logic [NH_LEN_W-1:0]   wr_len,
  input  logic [NH_PORT_W-1:0]  wr_port,
  input  logic                  swap,
  output logic                  active_bank
);

  localparam int unsigned BANKS = 2;

  logic      act_q;
  nh_entry_t wr_ent;
  nh_entry_t [ENTRIES-1:0] bank_tbl [BANKS];
  nh_entry_t [ENTRIES-1:0] live_tbl;

  assign wr_ent.vld  = wr_vld;
  assign wr_ent.pfx  = wr_prefix;
  assign wr_ent.len  = wr_len;
  assign wr_ent.port = wr_port;

  // Two banks. A bank takes a write only while it is the shadow one.
  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic bank_we;
    assign bank_we = wr_en && (wr_bank == 1'(b)) && (act_q != 1'(b));
    nh_bank #(
      .ENTRIES (ENTRIES),
      .IDX_W   (IDX_W)
    ) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (bank_we),
      .idx   (wr_idx),
      .wdata (wr_ent),
      .tbl   (bank_tbl[b])
    );
  end

  assign live_tbl = bank_tbl[act_q];

  // The search runs in the accepting cycle against the bank that is active
  // before the edge, so a swap on that edge cannot reach it.
  logic                 srch_hit;
  logic [NH_PORT_W-1:0] srch_port;

  nh_match #(
    .ENTRIES (ENTRIES)
  ) u_match (
    .key  (req_addr),
    .tbl  (live_tbl),
    .hit  (srch_hit),
    .port (srch_port)
  );

  // The bank flips on the edge that follows a swap pulse.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
    end else if (swap) begin
      act_q <= ~act_q;
    end
  end

  // Single-stage response register with valid/ready.
  logic                 rsp_vld_q;
  logic                 rsp_hit_q;
  logic [NH_PORT_W-1:0] rsp_port_q;
  logic                 accept;

  assign req_ready = !rsp_vld_q || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_vld_q  <= 1'b0;
      rsp_hit_q  <= 1'b0;
      rsp_port_q <= '0;
    end else begin
      if (accept) begin
        rsp_vld_q  <= 1'b1;
        rsp_hit_q  <= srch_hit;
        rsp_port_q <= srch_hit ? srch_port : dflt_port;
      end else if (rsp_ready) begin
        rsp_vld_q  <= 1'b0;
      end
    end
  end

  assign rsp_valid   = rsp_vld_q;
  assign rsp_hit     = rsp_hit_q;
  assign rsp_port    = rsp_port_q;
  assign active_bank = act_q;

endmodule

// File: rtl/nh_lookup_chk.sv
module nh_lookup_chk
  import nh_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic                 rsp_valid,
  input logic                 rsp_ready,
  input logic                 rsp_hit,
  input logic [NH_PORT_W-1:0] rsp_port,
  input logic [NH_PORT_W-1:0] dflt_port,
  input logic                 swap,
  input logic                 active_bank
);

  assert_accept_gives_rsp_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  assert_no_spurious_rsp_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!rsp_valid && !(req_valid && req_ready)) |=> !rsp_valid);

  assert_rsp_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_port) && $stable(rsp_hit)));

  assert_stall_blocks_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  assert_miss_default_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (rsp_hit || (rsp_port == $past(dflt_port))));

  assert_swap_flips_R8: assert property (@(posedge clk) disable iff (!rst_n)
    swap |=> (active_bank != $past(active_bank)));

  assert_bank_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !swap |=> $stable(active_bank));

endmodule

bind nh_lookup_top nh_lookup_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .rsp_hit     (rsp_hit),
  .rsp_port    (rsp_port),
  .dflt_port   (dflt_port),
  .swap        (swap),
  .active_bank (active_bank)
);

// File: tb/test_nh_lookup_top.sv
`timescale 1ns/1ps
module test_nh_lookup_top;
  import nh_pkg::*;

  localparam int ENT = 16;
  localparam int IW  = 4;
  localparam int AW  = NH_ADDR_W;
  localparam int LW  = NH_LEN_W;
  localparam int PW  = NH_PORT_W;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_ready, rsp_valid, rsp_ready, rsp_hit;
  logic [AW-1:0] req_addr;
  logic [PW-1:0] rsp_port, dflt_port;
  logic          wr_en, wr_bank, wr_vld, swap, active_bank;
  logic [IW-1:0] wr_idx;
  logic [AW-1:0] wr_prefix;
  logic [LW-1:0] wr_len;
  logic [PW-1:0] wr_port;

  always #10 clk = ~clk;

  nh_lookup_top #(.ENTRIES(ENT), .IDX_W(IW)) i_nh_lookup_top (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_hit(rsp_hit), .rsp_port(rsp_port), .dflt_port(dflt_port),
    .wr_en(wr_en), .wr_bank(wr_bank), .wr_idx(wr_idx), .wr_vld(wr_vld),
    .wr_prefix(wr_prefix), .wr_len(wr_len), .wr_port(wr_port),
    .swap(swap), .active_bank(active_bank)
  );

  int checks = 0;
  int errors = 0;

  // Independent model of both banks.
  logic          m_vld  [2][ENT];
  logic [AW-1:0] m_pfx  [2][ENT];
  int            m_len  [2][ENT];
  logic [PW-1:0] m_port [2][ENT];
  int            m_act;
  logic [31:0]   rng = 32'h1234_5678;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Longest match computed from shifted values rather than masks.
  task automatic model(input logic [31:0] a, output logic eh, output logic [PW-1:0] ep,
                       output int nm);
    int best;
    best = -1; eh = 0; ep = dflt_port; nm = 0;
    for (int i = 0; i < ENT; i++) begin
      if (m_vld[m_act][i]) begin
        int l;
        logic [63:0] x, y;
        l = (m_len[m_act][i] > 32) ? 32 : m_len[m_act][i];
        x = {32'b0, a} >> (32 - l);
        y = {32'b0, m_pfx[m_act][i]} >> (32 - l);
        if (x == y) begin
          nm++;
          if (l > best) begin best = l; eh = 1; ep = m_port[m_act][i]; end
        end
      end
    end
  endtask

  task automatic wr(input int bank, input int idx, input bit v, input logic [31:0] p,
                    input int len, input int port);
    @(negedge clk);
    wr_en = 1; wr_bank = bank[0]; wr_idx = IW'(idx); wr_vld = v;
    wr_prefix = p; wr_len = LW'(len); wr_port = PW'(port);
    @(negedge clk);
    wr_en = 0;
    if (bank != m_act) begin
      m_vld[bank][idx] = v; m_pfx[bank][idx] = p;
      m_len[bank][idx] = len; m_port[bank][idx] = PW'(port);
    end
  endtask

  task automatic lookup(input logic [31:0] a, output logic h, output logic [PW-1:0] p);
    @(negedge clk);
    req_valid = 1; req_addr = a; rsp_ready = 1;
    @(negedge clk);
    req_valid = 0;
    h = rsp_hit; p = rsp_port;
  endtask

  task automatic probe(input logic [31:0] a, input string force_tag);
    logic eh, h;
    logic [PW-1:0] ep, p;
    int nm;
    string tag;
    model(a, eh, ep, nm);
    lookup(a, h, p);
    if (force_tag != "") tag = force_tag;
    else if (!eh) tag = "R5";
    else if (nm > 1) tag = "R4";
    else tag = "R3";
    chk((h == eh) && (p == ep), tag, $sformatf("addr=%08h {hit,port}", a),
        {h, p}, {eh, ep});
  endtask

  task automatic sweep(input int n_rand);
    for (int i = 0; i < ENT; i++) begin
      if (m_vld[m_act][i]) begin
        int l;
        logic [31:0] host;
        l = (m_len[m_act][i] > 32) ? 32 : m_len[m_act][i];
        host = (l >= 32) ? 32'h0 : (32'hFFFF_FFFF >> l);
        probe(m_pfx[m_act][i], "");
        probe(m_pfx[m_act][i] | host, "");
        if (l > 0) probe(m_pfx[m_act][i] ^ (32'h1 << (32 - l)), "");
      end
    end
    for (int b = 0; b < 32; b++) probe(32'h1 << b, "");
    for (int k = 0; k < n_rand; k++) begin
      rng ^= rng << 13; rng ^= rng >> 17; rng ^= rng << 5;
      probe(rng, "");
    end
  endtask

  task automatic do_swap(input bit with_req, input logic [31:0] a);
    @(negedge clk);
    swap = 1;
    if (with_req) begin req_valid = 1; req_addr = a; rsp_ready = 1; end
    @(negedge clk);
    swap = 0; req_valid = 0;
    m_act = 1 - m_act;
  endtask

  task automatic load_table_a(input int bank);
    wr(bank, 0, 1, 32'h0A00_0000, 8,  1);
    wr(bank, 1, 1, 32'h0A01_0000, 16, 2);
    wr(bank, 2, 1, 32'h0A01_0200, 24, 3);
    wr(bank, 3, 1, 32'hC0A8_0000, 16, 4);
    wr(bank, 4, 1, 32'h0A01_0203, 32, 5);
    wr(bank, 6, 1, 32'hAC10_0000, 12, 7);
    wr(bank, 7, 1, 32'hC0A8_0000, 16, 8);
    wr(bank, 8, 1, 32'hC0A8_0101, 40, 9);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic h, eh;
    logic [PW-1:0] p, ep, held;
    int nm;
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < ENT; i++) begin
        m_vld[b][i] = 0; m_pfx[b][i] = 0; m_len[b][i] = 0; m_port[b][i] = 0;
      end
    m_act = 0;
    rst_n = 0; req_valid = 0; req_addr = 0; rsp_ready = 1; dflt_port = 4'd9;
    wr_en = 0; wr_bank = 0; wr_idx = 0; wr_vld = 0; wr_prefix = 0; wr_len = 0;
    wr_port = 0; swap = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R9 reset state, R1 ready when empty
    chk(!rsp_valid, "R9", "rsp_valid after reset", rsp_valid, 0);
    chk(active_bank == 0, "R9", "active_bank after reset", active_bank, 0);
    chk(req_ready, "R1", "req_ready when idle", req_ready, 1);
    probe(32'h0A01_0203, "R9");

    // R6: shadow bank filled, active bank still empty; write to active ignored
    load_table_a(1);
    probe(32'h0A01_0203, "R6");
    wr(0, 0, 1, 32'h0000_0000, 0, 13);
    probe(32'h0102_0304, "R6");

    // R8: plain swap
    do_swap(0, 0);
    chk(active_bank == 1, "R8", "active_bank after swap", active_bank, 1);
    probe(32'h0A01_0203, "R8");

    // R3 R4 R5 sweep on table A, then with another default port
    sweep(150);
    dflt_port = 4'd12;
    probe(32'h0102_0304, "R5");
    sweep(100);

    // R2 back-pressure: first response frozen, second request waits
    @(negedge clk);
    rsp_ready = 0; req_valid = 1; req_addr = 32'h0A01_0209;
    @(negedge clk);
    held = rsp_port;
    chk(rsp_valid && held == 4'd3, "R2", "stalled first response", held, 3);
    req_addr = 32'hC0A8_0505;
    for (int k = 0; k < 3; k++) begin
      chk(!req_ready, "R2", "req_ready while stalled", req_ready, 0);
      chk(rsp_valid && rsp_port == held, "R2", "held port", rsp_port, held);
      @(negedge clk);
    end
    rsp_ready = 1;
    @(negedge clk);
    req_valid = 0;
    chk(rsp_valid && rsp_hit && rsp_port == 4'd4, "R1", "second response after drain",
        rsp_port, 4);
    @(negedge clk);
    chk(!rsp_valid, "R1", "rsp_valid falls when drained", rsp_valid, 0);

    // Build table B in bank 0: table A, default route, host route removed
    load_table_a(0);
    wr(0, 5, 1, 32'h0000_0000, 0, 6);
    wr(0, 4, 0, 32'h0A01_0203, 32, 5);
    // R6: write aimed at the active bank must not add a route
    wr(1, 10, 1, 32'h0A01_0203, 32, 14);
    probe(32'h0A01_0203, "R6");
    probe(32'h0B00_0001, "R6");

    // R8: swap on the same edge as an accepted request
    model(32'h0A01_0203, eh, ep, nm);
    do_swap(1, 32'h0A01_0203);
    chk(rsp_valid && rsp_port == ep && rsp_hit == eh, "R8", "request in swap cycle",
        {rsp_hit, rsp_port}, {eh, ep});
    chk(active_bank == 0, "R8", "active_bank after second swap", active_bank, 0);
    // R7: removed host route no longer wins
    probe(32'h0A01_0203, "R7");
    lookup(32'h0A01_0203, h, p);
    chk(p == 4'd3, "R7", "fallback to /24", p, 3);
    // R3 default route on the new table
    probe(32'h0B00_0001, "R3");
    sweep(150);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule